// File: doc/BRIEF.md
# Falling-Edge Trigger Unit with Set/Clear Enable Aliases

This block watches sixteen asynchronous input pins and, for every channel whose trigger-enable bit is 1, emits a one-cycle interrupt pulse and an identical one-cycle DMA-event pulse when that pin goes from high to low. Each pin is brought into the clock domain by a two-flop synchronizer. A third flop holds the previous synchronized sample. A falling edge is seen when the previous sample is 1 and the current sample is 0.

Software cannot write the trigger-enable register directly. It changes the register only through two alias words on a simple 32-bit register bus. A 1 written to the set alias turns the matching enable bit on. A 1 written to the clear alias turns it off. Zeros written to either alias leave the bits alone. Both aliases read back the hidden enable value in bits 15..0, and bits 31..16 read as zero. Reads are combinational. A write is applied at the rising clock edge on which the write strobe is sampled.

Top module: `fet_top`

## Requirements
- R1: On each of the 16 channels, a falling edge on an enabled input produces exactly one pulse on `irq_o` and one pulse on `evt_o` for that channel. Both pulses last one cycle and occur in the same cycle.
- R2: A pin driven low just after clock edge k yields its pulse in the cycle that starts at rising edge k+3. The output is low in the cycles before that and in the cycle after it.
- R3: A write to word address 0 (set alias) sets every enable bit whose write-data bit (15..0) is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A write to word address 1 (clear alias) clears every enable bit whose write-data bit (15..0) is 1. Enable bits whose write-data bit is 0 keep their value.
- R5: Reading address 0 or address 1 returns the enable register in bits 15..0, with bits 31..16 equal to 0. Any other address reads as 0.
- R6: Write-data bits 31..16 have no effect on the enable register through either alias.
- R7: After reset, every enable bit is 0, both aliases read 0, and no pulses are produced.
- R8: A disabled channel produces no pulse. A rising edge produces no pulse. A channel enabled while its input is already low produces no pulse until the input rises and falls again.
- R9: The pulse for an edge is gated by the enable value held before a write that is sampled on the same rising edge that registers the pulse. A clear sampled one edge earlier suppresses the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 16 | Asynchronous channel inputs |
| bus_addr | input | 2 | Word address: 0 selects the set alias, 1 selects the clear alias |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data; only bits 15..0 are used |
| bus_rdata | output | 32 | Combinational read data for the addressed word |
| irq_o | output | 16 | Per-channel interrupt pulse |
| evt_o | output | 16 | Per-channel DMA-event pulse |

## Verification
A bus write to the enable register and a detected edge on the same channel can coincide: the clear strobe and the pulse register are clocked by the same rising edge. The bench drops one pin and times a clear write to that channel so that it is sampled either on the edge that registers the pulse or on the edge before it. It then expects a pulse in the first case and none in the second. In both cases it reads the enable value back afterwards to confirm the clear took effect.

// File: rtl/fet_pkg.sv
package fet_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    ALIAS_NONE = 2'd0,
    ALIAS_SET  = 2'd1,
    ALIAS_CLR  = 2'd2
  } alias_e;
endpackage

// File: rtl/fet_sync.sv
module fet_sync #(
  parameter int NCH    = 16,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] d_i,
  output logic [NCH-1:0] q_o
);
  logic [NCH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [NCH-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_rest
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fet_en_reg.sv
module fet_en_reg
  import fet_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  alias_e         sel_i,
  input  logic           wr_i,
  input  logic [NCH-1:0] wmask_i,
  output logic [NCH-1:0] en_o
);
  logic [NCH-1:0] en_q, en_d;
  logic           en_we;

  assign en_we = wr_i && (sel_i != ALIAS_NONE);

  always_comb begin
    en_d = en_q;
    unique case (sel_i)
      ALIAS_SET: en_d = en_q | wmask_i;
      ALIAS_CLR: en_d = en_q & ~wmask_i;
      default:   en_d = en_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assign en_o = en_q;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      p_set_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == ALIAS_SET && wmask_i[c]) |=> en_o[c]);
      p_clr_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == ALIAS_CLR && wmask_i[c]) |=> !en_o[c]);
    end
  endgenerate

  p_hold_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i || sel_i == ALIAS_NONE) |=> $stable(en_o));
endmodule

// File: rtl/fet_edge.sv
module fet_edge #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] smp_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] irq_o,
  output logic [NCH-1:0] evt_o
);
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] fall;
  logic [NCH-1:0] pulse_d;
  logic [NCH-1:0] irq_q, evt_q;

  assign fall    = prev_q & ~smp_i;
  assign pulse_d = fall & en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irq_q  <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= smp_i;
      irq_q  <= pulse_d;
      evt_q  <= pulse_d;
    end
  end

  assign irq_o = irq_q;
  assign evt_o = evt_q;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] |=> !irq_o[c]);
      p_fall_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] |-> !$past(smp_i[c]));
    end
  endgenerate
endmodule

// File: rtl/fet_top.sv
module fet_top
  import fet_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int AW       = 2,
  parameter int SET_WORD = 0,
  parameter int CLR_WORD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   pin_i,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [NCH-1:0]   irq_o,
  output logic [NCH-1:0]   evt_o
);
  localparam logic [AW-1:0] SET_A = AW'(SET_WORD);
  localparam logic [AW-1:0] CLR_A = AW'(CLR_WORD);
  localparam int            PAD_W = BUS_W - NCH;

  logic [1:0]     rst_pipe;
  logic           rst_sync_n;
  alias_e         sel;
  logic [NCH-1:0] smp;
  logic [NCH-1:0] en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    if (bus_addr == SET_A)      sel = ALIAS_SET;
    else if (bus_addr == CLR_A) sel = ALIAS_CLR;
    else                        sel = ALIAS_NONE;
  end

  fet_sync #(.NCH(NCH), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (pin_i),
    .q_o   (smp)
  );

  fet_en_reg #(.NCH(NCH)) u_en (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel_i   (sel),
    .wr_i    (bus_wr),
    .wmask_i (bus_wdata[NCH-1:0]),
    .en_o    (en)
  );

  fet_edge #(.NCH(NCH)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .smp_i (smp),
    .en_i  (en),
    .irq_o (irq_o),
    .evt_o (evt_o)
  );

  assign bus_rdata = (sel != ALIAS_NONE) ? {{PAD_W{1'b0}}, en} : '0;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chk
      p_pulse_enabled_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
        irq_o[c] |-> $past(en[c]));
    end
  endgenerate

  p_evt_tracks_irq_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt_o == irq_o);
  p_quiet_reset_r7: assert property (@(posedge clk)
    !rst_sync_n |=> (irq_o == '0));
endmodule

// File: tb/fet_top_tb.sv
module fet_top_tb;
  localparam int PERIOD = 10;
  localparam int NCH    = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pin;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] irq, evt;

  int total = 0;
  int bad   = 0;
  int pcnt [NCH];
  int base [NCH];
  int mism = 0;

  always #(PERIOD/2) clk = ~clk;

  fet_top u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq), .evt_o(evt)
  );

  // vector: [48] 1 = clear alias, [47:16] write data, [15:0] expected enable
  localparam logic [48:0] VEC [7] = '{
    {1'b0, 32'h0000_00FF, 16'h00FF},
    {1'b0, 32'hFFFF_0100, 16'h01FF},
    {1'b1, 32'h0000_0003, 16'h01FC},
    {1'b1, 32'h0000_0000, 16'h01FC},
    {1'b0, 32'h0000_0000, 16'h01FC},
    {1'b1, 32'hFFFF_0000, 16'h01FC},
    {1'b0, 32'h0000_8000, 16'h81FC}
  };

  initial for (int c = 0; c < NCH; c++) pcnt[c] = 0;

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) pcnt[c] += int'(irq[c]);
    if (irq !== evt) mism++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic snap();
    for (int c = 0; c < NCH; c++) base[c] = pcnt[c];
  endtask

  task automatic cnt_chk(input logic [15:0] exp, input string tag);
    logic [15:0] got;
    got = '0;
    for (int c = 0; c < NCH; c++) got[c] = ((pcnt[c] - base[c]) == 1);
    for (int c = 0; c < NCH; c++)
      if ((pcnt[c] - base[c]) > 1) got[c] = 1'bx;
    chk(got === exp, tag, {16'h0, got}, {16'h0, exp});
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin = 16'hFFFF; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(5);

    // R7: reset state
    rd_chk(2'd0, 32'h0, "R7 set alias after reset");
    rd_chk(2'd1, 32'h0, "R7 clear alias after reset");
    chk(irq === 16'h0, "R7 no pulse after reset", {16'h0, irq}, 32'h0);

    // R3 R4 R5 R6: vector walk
    for (int v = 0; v < 7; v++) begin
      wr(VEC[v][48] ? 2'd1 : 2'd0, VEC[v][47:16]);
      rd_chk(2'd0, {16'h0, VEC[v][15:0]}, $sformatf("R3 R4 R6 set-alias read vec %0d", v));
      rd_chk(2'd1, {16'h0, VEC[v][15:0]}, $sformatf("R5 clear-alias read vec %0d", v));
    end
    rd_chk(2'd3, 32'h0, "R5 unmapped address reads zero");
    wr(2'd3, 32'hFFFF_FFFF);
    rd_chk(2'd0, 32'h0000_81FC, "R5 write to unmapped address ignored");

    // R1 R8: falling edges with mixed enables
    snap();
    @(negedge clk); pin = 16'h0000;
    wait_n(6);
    cnt_chk(16'h81FC, "R1 R8 pulses match enables");
    chk(mism == 0, "R1 irq equals evt", mism, 0);
    snap();
    @(negedge clk); pin = 16'hFFFF;
    wait_n(6);
    cnt_chk(16'h0000, "R8 rising edge no pulse");

    // R8: enable while already low
    wr(2'd1, 32'h0000_FFFF);
    @(negedge clk); pin = 16'h0000;
    wait_n(6);
    snap();
    wr(2'd0, 32'h0000_FFFF);
    wait_n(6);
    cnt_chk(16'h0000, "R8 late enable while low");
    @(negedge clk); pin = 16'hFFFF;
    wait_n(6);
    snap();
    @(negedge clk); pin = 16'h0000;
    wait_n(6);
    cnt_chk(16'hFFFF, "R1 all channels pulse once");
    chk(mism == 0, "R1 irq equals evt all", mism, 0);
    @(negedge clk); pin = 16'hFFFF;
    wait_n(6);

    // R2: latency
    @(negedge clk); pin[5] = 1'b0;
    @(negedge clk); chk(irq[5] === 1'b0, "R2 cycle 1 low", {31'h0, irq[5]}, 0);
    @(negedge clk); chk(irq[5] === 1'b0, "R2 cycle 2 low", {31'h0, irq[5]}, 0);
    @(negedge clk); chk(irq[5] === 1'b1 && evt[5] === 1'b1, "R2 pulse at edge 3", {31'h0, irq[5]}, 1);
    @(negedge clk); chk(irq[5] === 1'b0, "R2 pulse ends", {31'h0, irq[5]}, 0);
    pin[5] = 1'b1;
    wait_n(4);

    // R9 case A: clear sampled one edge before pulse register -> no pulse
    @(negedge clk); pin[3] = 1'b0;
    @(negedge clk); bus_addr = 2'd1; bus_wdata = 32'h0000_0008; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk); chk(irq[3] === 1'b0, "R9 early clear suppresses", {31'h0, irq[3]}, 0);
    rd_chk(2'd0, 32'h0000_FFF7, "R9 R4 enable cleared early");
    wr(2'd0, 32'h0000_0008);
    @(negedge clk); pin[3] = 1'b1;
    wait_n(4);

    // R9 case B: clear sampled on the pulse edge -> pulse still out
    @(negedge clk); pin[3] = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_addr = 2'd1; bus_wdata = 32'h0000_0008; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk(irq[3] === 1'b1, "R9 same-edge clear keeps pulse", {31'h0, irq[3]}, 1);
    rd_chk(2'd1, 32'h0000_FFF7, "R9 R4 enable cleared same edge");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule